// File: doc/BRIEF.md
# Serial Transmit Framer with Sticky Parity

This block turns characters written by a host into asynchronous serial frames. Each frame begins with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and one or two high stop bits close the frame. Between frames the line idles high. The host reaches the block through a write-only port with a 3-bit address. A line-control register sets the word length, the stop-bit count, the parity mode and the break override. A one-deep holding register takes each character. The host writes a 16-bit bit-rate divisor through the data and interrupt-enable addresses while the divisor-access bit is set.

The parity stage has five settings: none, odd, even, forced mark and forced space. A break control masks the serial output to low for as long as it is set. While break is set, the framer underneath keeps its timing, so a frame in progress finishes on schedule and is simply not seen on the line. Bit timing comes from a free-running generator. A divisor counter produces a sample tick, and every 16 sample ticks make one bit period.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, the serial output is high and the holding register is empty. The line-control register is all zero: 5-bit words, one stop bit, no parity, break off, divisor access off. The divisor is 1. A data write made straight after reset is sent as a 5-bit frame.
- R2: A frame has one start bit at 0, then the data bits LSB first, then the optional parity bit, then the stop bits at 1. Line-control bits 1:0 select the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bit 2 selects one stop bit when 0 and two when 1.
- R3: When line-control bit 3 is 0, no parity bit is sent, whatever bits 4 and 5 hold. The bit after the last data bit is then a stop bit.
- R4: When bit 3 is 1 and bit 5 is 0, bit 4 = 0 gives odd parity: the data bits and the parity bit together hold an odd number of ones. Bit 4 = 1 gives even parity. Only the bits of the selected word length count.
- R5: When bits 3 and 5 are both 1, bit 4 = 0 forces the parity bit to 1 and bit 4 = 1 forces it to 0.
- R6: While line-control bit 6 is 1, the serial output is 0. The output goes low no more than two clocks after the write that sets the bit. When the bit is cleared, the frame in progress shows its remaining bits at their original bit times.
- R7: While line-control bit 7 is 1, a write to address 0 sets the divisor low byte and a write to address 1 sets the divisor high byte. Neither write fills the holding register or starts a frame. While bit 7 is 0, a write to address 1 has no effect on the line or on the holding flag.
- R8: One bit lasts 16 times the divisor in clocks. A divisor of 0 behaves as 1.
- R9: A write to address 0 with bit 7 clear makes the holding-empty output 0 by the next clock. The character moves to the shifter only at a frame boundary, and the flag then returns to 1. A character waiting at the end of a frame starts at once, with no idle bit in between.
- R10: A data write made while the holding register is still full replaces the waiting character. Only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 is data or divisor low, 1 is divisor high, 3 is line control |
| wr_data | input | 8 | Write data |
| ser_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | High when the holding register can take a character |
| tx_busy | output | 1 | High while a frame is being shifted |

## Verification
Two conditions are hard to reach from the ports. The first is a break that starts and ends inside one frame, after which the later data bits must land at their original times. The second is a second and a third character written while the shifter is still busy. The bench waits for the falling edge of a start bit and counts clocks from that edge. It then places its line-control and data writes at known bit midpoints, so each write falls in a chosen bit of the running frame. It also measures the low time of an all-zero frame to check the divisor arithmetic, including the divisor-zero case.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int FRAME_MAX = 12;
  localparam int REM_W     = 4;

  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DHI  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LINE = 3'd3;

  typedef struct packed {
    logic       dsel;      // divisor access
    logic       brk;       // break override
    logic       stick;     // forced parity
    logic       even;      // even / space select
    logic       pen;       // parity enable
    logic       two_stop;  // two stop bits
    logic [1:0] wlen;      // 5 + wlen data bits
  } line_ctl_t;

  function automatic logic [DATA_W-1:0] word_mask(logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

  function automatic logic parity_of(logic [DATA_W-1:0] d, line_ctl_t c);
    logic x;
    x = ^(d & word_mask(c.wlen));
    if (c.stick) return ~c.even;
    return c.even ? x : ~x;
  endfunction

  function automatic logic [REM_W-1:0] frame_len(line_ctl_t c);
    return REM_W'(7) + {2'b00, c.wlen} + {3'b000, c.pen} + {3'b000, c.two_stop};
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(logic [DATA_W-1:0] d, line_ctl_t c);
    logic [FRAME_MAX-1:0] f;
    logic [REM_W-1:0]     pidx;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < 5 + int'(c.wlen)) f[i+1] = d[i];
    end
    pidx = REM_W'(6) + {2'b00, c.wlen};
    if (c.pen) f[pidx] = parity_of(d, c);
    return f;
  endfunction

endpackage

// File: rtl/utx_regs.sv
module utx_regs
  import utx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output line_ctl_t         line_ctl,
  output logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  localparam int HI_W = DIV_W - 8;

  line_ctl_t         ctl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] hold_q;
  logic              full_q;

  logic sel_lo, wr_hold, wr_dlo, wr_dhi, wr_line;

  always_comb begin
    sel_lo  = wr_en && (wr_addr == ADR_DATA);
    wr_hold = sel_lo && !ctl_q.dsel;
    wr_dlo  = sel_lo && ctl_q.dsel;
    wr_dhi  = wr_en && (wr_addr == ADR_DHI) && ctl_q.dsel;
    wr_line = wr_en && (wr_addr == ADR_LINE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_line) ctl_q <= line_ctl_t'(wr_data);
      if (wr_dlo)  div_q[7:0] <= wr_data;
      if (wr_dhi)  div_q[DIV_W-1:8] <= HI_W'(wr_data);
      if (wr_hold) hold_q <= wr_data;
      if (wr_hold)     full_q <= 1'b1;
      else if (take)   full_q <= 1'b0;
    end
  end

  assign line_ctl  = ctl_q;
  assign divisor   = div_q;
  assign hold_data = hold_q;
  assign hold_full = full_q;

  a_r7_divisor_write_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_DATA && ctl_q.dsel && !full_q) |=> !full_q);

  a_r10_last_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |=> (full_q && hold_q == $past(wr_data)));

  a_r9_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_hold) |=> !full_q);

endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             samp_tick,
  output logic             bit_tick
);

  localparam int OS_W  = $clog2(OVERSAMPLE);
  localparam int GAP_W = DIV_W + OS_W + 1;

  function automatic logic [DIV_W-1:0] eff_div(logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [OS_W-1:0]  os_q;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_eff   = eff_div(divisor);
    samp_tick = (cnt_q >= div_eff - DIV_W'(1));
    bit_tick  = samp_tick && (os_q == OS_W'(OVERSAMPLE - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      os_q  <= '0;
    end else begin
      cnt_q <= samp_tick ? '0 : cnt_q + DIV_W'(1);
      if (samp_tick) os_q <= bit_tick ? '0 : os_q + OS_W'(1);
    end
  end

  // Interval monitor for the bit-period assertion
  logic [GAP_W-1:0] gap_q;
  logic             seen_q, chg_q;
  logic [DIV_W-1:0] div_prev_q;
  logic             div_chg;

  assign div_chg = (divisor != div_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      seen_q     <= 1'b0;
      chg_q      <= 1'b0;
      div_prev_q <= '0;
    end else begin
      div_prev_q <= divisor;
      gap_q      <= bit_tick ? '0 : gap_q + GAP_W'(1);
      if (bit_tick) seen_q <= 1'b1;
      if (bit_tick)     chg_q <= div_chg;
      else if (div_chg) chg_q <= 1'b1;
    end
  end

  a_r8_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && seen_q && !chg_q && !div_chg)
      |-> (gap_q == GAP_W'(OVERSAMPLE) * GAP_W'(div_eff) - GAP_W'(1)));

  a_r8_zero_as_one: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0 && div_prev_q == '0) |-> samp_tick);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  line_ctl_t         line_ctl,
  output logic              take,
  output logic              busy,
  output logic              ser_raw
);

  logic [FRAME_MAX-1:0] shreg_q;
  logic [REM_W-1:0]     rem_q;
  logic                 busy_q;
  logic                 boundary;

  always_comb begin
    boundary = bit_tick && (!busy_q || rem_q == REM_W'(1));
    take     = boundary && hold_full;
    ser_raw  = busy_q ? shreg_q[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      rem_q   <= '0;
      busy_q  <= 1'b0;
    end else if (bit_tick) begin
      if (take) begin
        shreg_q <= build_frame(hold_data, line_ctl);
        rem_q   <= frame_len(line_ctl);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (rem_q == REM_W'(1)) begin
          busy_q <= 1'b0;
          rem_q  <= '0;
        end else begin
          shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
          rem_q   <= rem_q - REM_W'(1);
        end
      end
    end
  end

  assign busy = busy_q;

  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy_q && !ser_raw));

  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rem_q >= REM_W'(7) && rem_q <= REM_W'(FRAME_MAX)));

  a_r9_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(rem_q) && $stable(shreg_q)));

  a_r2_last_bit_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q == REM_W'(1)) |-> ser_raw);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import utx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16,
  parameter int DIV_RESET  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       ser_out,
  output logic       hold_empty,
  output logic       tx_busy
);

  line_ctl_t         line_ctl;
  logic [DIV_W-1:0]  divisor;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              take;
  logic              samp_tick;
  logic              bit_tick;
  logic              busy;
  logic              ser_raw;
  logic              ser_q;

  utx_regs #(
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .take      (take),
    .line_ctl  (line_ctl),
    .divisor   (divisor),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  utx_baud #(
    .DIV_W      (DIV_W),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .divisor   (divisor),
    .samp_tick (samp_tick),
    .bit_tick  (bit_tick)
  );

  utx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .line_ctl  (line_ctl),
    .take      (take),
    .busy      (busy),
    .ser_raw   (ser_raw)
  );

  // Break masks the registered line; the shifter is never stalled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_q <= 1'b1;
    else        ser_q <= line_ctl.brk ? 1'b0 : ser_raw;
  end

  assign ser_out    = ser_q;
  assign hold_empty = !hold_full;
  assign tx_busy    = busy;

  a_r6_break_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_ctl.brk) |-> !ser_out);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_ctl.brk) && !$past(busy)) |-> ser_out);

  a_r6_break_keeps_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ctl.brk && busy && !bit_tick) |=> busy);

endmodule

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       ser_out;
  logic       hold_empty;
  logic       tx_busy;

  int tests_run  = 0;
  int tests_fail = 0;
  int period     = 16;
  bit done       = 0;
  logic rxb [12];

  uart_tx_framer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ser_out    (ser_out),
    .hold_empty (hold_empty),
    .tx_busy    (tx_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {line control, data}
  localparam logic [15:0] VEC [12] = '{
    16'h03A5, 16'h0BA5, 16'h1BA5, 16'h2BA5,
    16'h3BA5, 16'h0B01, 16'h1A7F, 16'h09FF,
    16'h3C00, 16'h341F, 16'h27C3, 16'h2E12
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    int n = 0;
    while (ser_out !== 1'b0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sample_frame(input int nbits, input int elapsed);
    clks(period / 2 - elapsed);
    rxb[0] = ser_out;
    for (int i = 1; i < nbits; i++) begin
      clks(period);
      rxb[i] = ser_out;
    end
  endtask

  function automatic logic exp_parity(logic [7:0] d, logic [7:0] l);
    int ones = 0;
    for (int i = 0; i < 5 + int'(l[1:0]); i++) ones += int'(d[i]);
    if (l[5]) return !l[4];
    if (l[4]) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic check_byte(input logic [7:0] exp, input int wl, input string tag);
    logic [7:0] got = '0;
    for (int i = 0; i < wl; i++) got[i] = rxb[i+1];
    chk(rxb[0] == 1'b0, {tag, " start"}, int'(rxb[0]), 0);
    chk(got == exp, {tag, " data"}, int'(got), int'(exp));
  endtask

  initial begin
    int cnt;
    bit stayed;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    clks(5);
    chk(ser_out == 1'b1, "R1 line high in reset", int'(ser_out), 1);
    chk(hold_empty == 1'b1, "R1 holding empty in reset", int'(hold_empty), 1);
    rst_n = 1'b1;
    clks(3);
    chk(ser_out == 1'b1 && !tx_busy, "R1 idle after reset", int'(ser_out), 1);

    // R1: default 5N1 framing
    wr(3'd0, 8'h15);
    chk(hold_empty == 1'b0, "R9 holding full after write", int'(hold_empty), 0);
    wait_start();
    sample_frame(7, 0);
    check_byte(8'h15, 5, "R1 default 5-bit");
    chk(rxb[6] == 1'b1, "R1 stop", int'(rxb[6]), 1);
    chk(hold_empty == 1'b1, "R9 holding empty after move", int'(hold_empty), 1);

    // Vector table: framing and parity modes
    for (int v = 0; v < 12; v++) begin
      logic [7:0] l, d;
      int wl, n, sidx;
      l = VEC[v][15:8];
      d = VEC[v][7:0];
      wl = 5 + int'(l[1:0]);
      n  = 1 + wl + int'(l[3]) + 1 + int'(l[2]);
      wr(3'd3, l);
      wr(3'd0, d);
      wait_start();
      sample_frame(n, 0);
      check_byte(d & (8'hFF >> (3 - int'(l[1:0]))), wl, "R2 vector");
      if (l[3]) begin
        chk(rxb[wl+1] == exp_parity(d, l), l[5] ? "R5 forced parity" : "R4 odd/even parity",
            int'(rxb[wl+1]), int'(exp_parity(d, l)));
      end
      sidx = wl + 1 + int'(l[3]);
      chk(rxb[sidx] == 1'b1, l[3] ? "R2 stop bit" : "R3 no parity slot is stop",
          int'(rxb[sidx]), 1);
      if (l[2]) chk(rxb[sidx+1] == 1'b1, "R2 second stop", int'(rxb[sidx+1]), 1);
    end

    // R9: back-to-back frames, no idle gap
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h81);
    wait_start();
    wr(3'd0, 8'h7E);
    chk(hold_empty == 1'b0, "R9 second char waiting", int'(hold_empty), 0);
    sample_frame(10, 2);
    check_byte(8'h81, 8, "R9 first of pair");
    cnt = 0;
    while (ser_out !== 1'b0 && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= 7 && cnt <= 9, "R9 no gap between frames", cnt, 8);
    sample_frame(10, 0);
    check_byte(8'h7E, 8, "R9 second of pair");

    // R10: overwrite while holding is full
    clks(40);
    wr(3'd0, 8'h11);
    wait_start();
    wr(3'd0, 8'h22);
    wr(3'd0, 8'h33);
    chk(hold_empty == 1'b0, "R10 holding full", int'(hold_empty), 0);
    sample_frame(10, 4);
    check_byte(8'h11, 8, "R10 running frame");
    wait_start();
    sample_frame(10, 0);
    check_byte(8'h33, 8, "R10 last write sent");
    stayed = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ser_out !== 1'b1) stayed = 0;
    end
    chk(stayed && hold_empty, "R10 overwritten char not sent", int'(stayed), 1);

    // R7/R8: divisor 3 via access bit
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h03);
    chk(hold_empty == 1'b1, "R7 divisor low write not data", int'(hold_empty), 1);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h03);
    stayed = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ser_out !== 1'b1) stayed = 0;
    end
    chk(stayed, "R7 divisor writes start no frame", int'(stayed), 1);
    wr(3'd0, 8'h00);
    wait_start();
    cnt = 0;
    while (ser_out === 1'b0 && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 9 * 48, "R8 bit time with divisor 3", cnt, 9 * 48);
    clks(200);

    // R8: divisor 0 acts as 1; R7: address 1 without access bit ignored
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h5A);
    chk(hold_empty == 1'b1, "R7 address 1 write ignored", int'(hold_empty), 1);
    clks(40);
    chk(ser_out == 1'b1, "R7 line idle after address 1 write", int'(ser_out), 1);
    wr(3'd0, 8'h00);
    wait_start();
    cnt = 0;
    while (ser_out === 1'b0 && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 9 * 16, "R8 divisor zero as one", cnt, 9 * 16);
    clks(60);

    // R6: break in the middle of a frame
    wr(3'd0, 8'h55);
    wait_start();
    clks(40);
    wr(3'd3, 8'h43);
    clks(14);
    chk(ser_out == 1'b0, "R6 break low at data bit 2", int'(ser_out), 0);
    clks(16);
    chk(ser_out == 1'b0, "R6 break low at data bit 3", int'(ser_out), 0);
    wr(3'd3, 8'h03);
    clks(44);
    chk(ser_out == 1'b1, "R6 data bit 6 on time after break", int'(ser_out), 1);
    clks(16);
    chk(ser_out == 1'b0, "R6 data bit 7 on time after break", int'(ser_out), 0);
    clks(16);
    chk(ser_out == 1'b1, "R6 stop after break", int'(ser_out), 1);

    // R6: break on an idle line holds until cleared
    wr(3'd3, 8'h40);
    clks(100);
    chk(ser_out == 1'b0, "R6 idle break held", int'(ser_out), 0);
    wr(3'd3, 8'h00);
    clks(2);
    chk(ser_out == 1'b1, "R6 line released", int'(ser_out), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

endmodule